// File: doc/BRIEF.md
# PCI Target Register Read Responder

This block answers PCI read transactions aimed at a small window of 32-bit operation registers. It watches the shared bus for an address phase. When the address falls inside its window and the command is a memory read or an I/O read, it claims the cycle with DEVSEL#. It then fetches the addressed word through a simple register-read port and returns it with TRDY#. Output enables stand in for the tri-state buffers, so the block can sit behind the pad ring of a larger controller.

The block completes at most one data phase per transaction. If the initiator shows a burst, it asserts STOP# together with TRDY#, which is a disconnect with data. One register index acts as a FIFO data port. A read of that port while the FIFO is empty ends with STOP# and no TRDY#, a retry. A successful FIFO read pulses a pop strobe toward the FIFO. Writes, configuration space, parity and bus mastering are left to other blocks.

Top module: `pciRdTgtTop`

## Requirements
- R1: A rising clock edge where FRAME# is sampled low after being high at the previous edge is an address phase. If the address is inside the window (`adIn[31:6]` equals `BASE_ADDR[31:6]` with 16 registers) and `cbeN` is 4'b0110 (memory read) or 4'b0010 (I/O read), DEVSEL# is driven low from the next clock. DEVSEL# stays low until the data phase or retry ends.
- R2: If IRDY# is low at the first edge after the address phase, the data word and TRDY# low appear in the third clock of the transaction, counting the address phase as clock 1.
- R3: If FRAME# and IRDY# are both low at the edge where the data is latched, STOP# is driven low together with TRDY# on that single data phase.
- R4: While IRDY# stays high after the address phase, TRDY# and STOP# stay high and DEVSEL# stays low. Data and TRDY# follow in the clock after IRDY# is first sampled low.
- R5: A read of register index 15 (the FIFO port) while `fifoEmpty` is high is answered with STOP# low, TRDY# high and the AD output enable low. No data is returned.
- R6: STOP# low with TRDY# high occurs only for the retry of R5.
- R7: After the completed data phase or the retry, TRDY#, STOP# and DEVSEL# are driven high with their enables on for exactly one clock. All enables are then released, and AD is never driven in that clock.
- R8: Byte enables in the data phase have no effect. `adOut` carries the full 32-bit `regData` value sampled at the edge where IRDY# is first seen low.
- R9: `fifoPop` is high for exactly one clock, the clock after a completed data phase from register index 15. It never pulses after a retry.
- R10: A transaction with an address outside the window, or with any other command, leaves every output enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rstN | input | 1 | Active-low reset |
| frameN | input | 1 | FRAME# from the bus |
| irdyN | input | 1 | IRDY# from the bus |
| adIn | input | 32 | AD bus as received |
| cbeN | input | 4 | Command or byte enables as received |
| adOut | output | 32 | Read data toward the AD pads |
| adOe | output | 1 | Enable for the AD drivers |
| trdyN | output | 1 | TRDY# value |
| trdyOe | output | 1 | Enable for TRDY# |
| stopN | output | 1 | STOP# value |
| stopOe | output | 1 | Enable for STOP# |
| devselN | output | 1 | DEVSEL# value |
| devselOe | output | 1 | Enable for DEVSEL# |
| regAddr | output | IDX_W | Word index of the register being read |
| regData | input | 32 | Register contents for `regAddr` |
| fifoEmpty | input | 1 | The FIFO behind index 15 is empty |
| fifoPop | output | 1 | Pop pulse for that FIFO |

## Verification
The assertions check these rules on every cycle:
- TRDY# is only asserted under DEVSEL#.
- A retry never drives AD, and it appears only when the FIFO reported empty.
- No second TRDY# follows a completed phase, and the release clock is exactly one clock long.
- Pops happen only after a completed data phase.

The exact clock in which data appears, and whether the bus was claimed at all, depend on the address, the command and the pattern of wait states. Only the bench scenarios show these. They also show that the returned word is the right one regardless of byte enables, and that STOP# is asserted on a burst but not on a plain read.

// File: rtl/pciRdTgtPkg.sv
package pciRdTgtPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLAIM,
    ST_XFER,
    ST_RETRY,
    ST_TURN
  } tgtState_e;

  typedef struct packed {
    logic latchAddr;
    logic loadData;
  } dpStrobe_t;

  localparam logic [3:0] CMD_IO_READ  = 4'b0010;
  localparam logic [3:0] CMD_MEM_READ = 4'b0110;

endpackage

// File: rtl/pciRdTgtDatapath.sv
module pciRdTgtDatapath
  import pciRdTgtPkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h4000_0000,
  parameter int REG_COUNT = 16,
  parameter int FIFO_IDX = 15,
  parameter bit CLAIM_IO = 1'b1,
  localparam int IDX_W = $clog2(REG_COUNT),
  localparam int DEC_LSB = IDX_W + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [31:0]      adIn,
  input  logic [3:0]       cbeN,
  input  dpStrobe_t        strobe,
  output logic             addrHit,
  output logic             selFifo,
  output logic [IDX_W-1:0] regAddr,
  input  logic [31:0]      regData,
  output logic [31:0]      adOut
);

  logic [IDX_W-1:0] idxQ;
  logic [31:0]      dataQ;
  logic             windowHit;
  logic             cmdHit;

  assign windowHit = (adIn[31:DEC_LSB] == BASE_ADDR[31:DEC_LSB]);

  generate
    if (CLAIM_IO) begin : g_ioClaim
      assign cmdHit = (cbeN == CMD_MEM_READ) || (cbeN == CMD_IO_READ);
    end else begin : g_memOnly
      assign cmdHit = (cbeN == CMD_MEM_READ);
    end
  endgenerate

  assign addrHit = windowHit && cmdHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ  <= '0;
      dataQ <= '0;
    end else begin
      if (strobe.latchAddr) idxQ  <= adIn[DEC_LSB-1:2];
      if (strobe.loadData)  dataQ <= regData;
    end
  end

  assign regAddr = idxQ;
  assign selFifo = (idxQ == IDX_W'(FIFO_IDX));
  assign adOut   = dataQ;

endmodule

// File: rtl/pciRdTgtCtrl.sv
module pciRdTgtCtrl
  import pciRdTgtPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      frameN,
  input  logic      irdyN,
  input  logic      addrHit,
  input  logic      selFifo,
  input  logic      fifoEmpty,
  output dpStrobe_t strobe,
  output logic      trdyN,
  output logic      stopN,
  output logic      devselN,
  output logic      ctlOe,
  output logic      adOe,
  output logic      fifoPop
);

  tgtState_e stateQ, stateD;
  logic      frameQ;
  logic      burstQ, burstD;
  logic      popQ, popD;
  logic      addrPhase;

  assign addrPhase = (stateQ == ST_IDLE) && frameQ && !frameN;

  always_comb begin
    stateD = stateQ;
    burstD = burstQ;
    popD   = 1'b0;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (addrPhase && addrHit) begin
          strobe.latchAddr = 1'b1;
          stateD = ST_CLAIM;
        end
      end
      ST_CLAIM: begin
        if (!irdyN) begin
          if (selFifo && fifoEmpty) begin
            stateD = ST_RETRY;
            burstD = 1'b0;
          end else begin
            strobe.loadData = 1'b1;
            stateD = ST_XFER;
            burstD = !frameN;
          end
        end
      end
      ST_XFER: begin
        if (!irdyN) begin
          stateD = ST_TURN;
          popD   = selFifo;
        end
      end
      ST_RETRY: begin
        if (!irdyN) stateD = ST_TURN;
      end
      ST_TURN: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      frameQ <= 1'b1;
      burstQ <= 1'b0;
      popQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      frameQ <= frameN;
      burstQ <= burstD;
      popQ   <= popD;
    end
  end

  assign devselN = !((stateQ == ST_CLAIM) || (stateQ == ST_XFER) || (stateQ == ST_RETRY));
  assign trdyN   = (stateQ != ST_XFER);
  assign stopN   = !((stateQ == ST_RETRY) || ((stateQ == ST_XFER) && burstQ));
  assign ctlOe   = (stateQ != ST_IDLE);
  assign adOe    = (stateQ == ST_XFER);
  assign fifoPop = popQ;

endmodule

// File: rtl/pciRdTgtTop.sv
module pciRdTgtTop
  import pciRdTgtPkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h4000_0000,
  parameter int REG_COUNT = 16,
  parameter int FIFO_IDX = 15,
  parameter bit CLAIM_IO = 1'b1,
  localparam int IDX_W = $clog2(REG_COUNT)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameN,
  input  logic             irdyN,
  input  logic [31:0]      adIn,
  input  logic [3:0]       cbeN,
  output logic [31:0]      adOut,
  output logic             adOe,
  output logic             trdyN,
  output logic             trdyOe,
  output logic             stopN,
  output logic             stopOe,
  output logic             devselN,
  output logic             devselOe,
  output logic [IDX_W-1:0] regAddr,
  input  logic [31:0]      regData,
  input  logic             fifoEmpty,
  output logic             fifoPop
);

  dpStrobe_t strobe;
  logic      addrHit;
  logic      selFifo;
  logic      ctlOe;

  pciRdTgtDatapath #(
    .BASE_ADDR(BASE_ADDR),
    .REG_COUNT(REG_COUNT),
    .FIFO_IDX (FIFO_IDX),
    .CLAIM_IO (CLAIM_IO)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .adIn   (adIn),
    .cbeN   (cbeN),
    .strobe (strobe),
    .addrHit(addrHit),
    .selFifo(selFifo),
    .regAddr(regAddr),
    .regData(regData),
    .adOut  (adOut)
  );

  pciRdTgtCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .frameN   (frameN),
    .irdyN    (irdyN),
    .addrHit  (addrHit),
    .selFifo  (selFifo),
    .fifoEmpty(fifoEmpty),
    .strobe   (strobe),
    .trdyN    (trdyN),
    .stopN    (stopN),
    .devselN  (devselN),
    .ctlOe    (ctlOe),
    .adOe     (adOe),
    .fifoPop  (fifoPop)
  );

  assign trdyOe   = ctlOe;
  assign stopOe   = ctlOe;
  assign devselOe = ctlOe;

endmodule

// File: rtl/pciRdTgtChecker.sv
module pciRdTgtChecker (
  input logic clk,
  input logic rstN,
  input logic irdyN,
  input logic adOe,
  input logic trdyN,
  input logic trdyOe,
  input logic stopN,
  input logic stopOe,
  input logic devselN,
  input logic fifoEmpty,
  input logic fifoPop
);

  AST_TRDY_UNDER_DEVSEL: assert property (@(posedge clk) disable iff (!rstN)
    (trdyOe && !trdyN) |-> !devselN); // R1

  AST_TRDY_AFTER_IRDY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(trdyN) |-> $past(!irdyN)); // R4

  AST_RETRY_NO_AD: assert property (@(posedge clk) disable iff (!rstN)
    (stopOe && !stopN && trdyN) |-> !adOe); // R5

  AST_RETRY_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(stopN) && trdyN) |-> $past(fifoEmpty)); // R6

  AST_ONE_DATA_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    (trdyOe && !trdyN && !irdyN) |=> (trdyOe && trdyN && stopN && devselN && !adOe)); // R7

  AST_RELEASE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (devselOeHigh && devselN) |=> !trdyOe); // R7

  AST_POP_AFTER_DATA: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> $past(trdyOe && !trdyN && !irdyN)); // R9

  AST_NO_POP_ON_RETRY: assert property (@(posedge clk) disable iff (!rstN)
    $past(stopOe && !stopN && trdyN) |-> !fifoPop); // R9

  logic devselOeHigh;
  assign devselOeHigh = trdyOe;

endmodule

bind pciRdTgtTop pciRdTgtChecker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .irdyN    (irdyN),
  .adOe     (adOe),
  .trdyN    (trdyN),
  .trdyOe   (trdyOe),
  .stopN    (stopN),
  .stopOe   (stopOe),
  .devselN  (devselN),
  .fifoEmpty(fifoEmpty),
  .fifoPop  (fifoPop)
);

// File: tb/test_pciRdTgtTop.sv
`timescale 1ns/1ps
module test_pciRdTgtTop;

  localparam logic [31:0] BASE = 32'h4000_0000;
  localparam int FIFO_SLOT = 15;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameN = 1'b1;
  logic        irdyN = 1'b1;
  logic [31:0] adIn = '0;
  logic [3:0]  cbeN = 4'hF;
  logic [31:0] adOut;
  logic        adOe, trdyN, trdyOe, stopN, stopOe, devselN, devselOe;
  logic [3:0]  regAddr;
  logic [31:0] regData;
  logic        fifoEmpty;
  logic        fifoPop;

  logic [31:0] regMem [16];
  logic [31:0] fifoMem [8];
  int fifoRd = 0;
  int fifoCnt = 0;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  assign fifoEmpty = (fifoCnt == 0);
  assign regData = (regAddr == 4'(FIFO_SLOT)) ?
                   ((fifoCnt > 0) ? fifoMem[fifoRd[2:0]] : 32'hDEAD_0000) :
                   regMem[regAddr];

  always @(posedge clk) begin
    if (fifoPop && fifoCnt > 0) begin
      fifoRd  <= fifoRd + 1;
      fifoCnt <= fifoCnt - 1;
    end
  end

  pciRdTgtTop i_pciRdTgtTop (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN),
    .adIn(adIn), .cbeN(cbeN), .adOut(adOut), .adOe(adOe),
    .trdyN(trdyN), .trdyOe(trdyOe), .stopN(stopN), .stopOe(stopOe),
    .devselN(devselN), .devselOe(devselOe), .regAddr(regAddr),
    .regData(regData), .fifoEmpty(fifoEmpty), .fifoPop(fifoPop)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h at %0t", tag, what, got, exp, $time);
    end
  endtask

  // Reference model of one clock: expected pin values for the target.
  task automatic expectPins(input string tag, input bit oe, input bit dev,
                            input bit trdy, input bit stop, input bit adEn,
                            input bit pop, input logic [31:0] data);
    chk(tag, "trdyOe", trdyOe, oe);
    chk(tag, "stopOe", stopOe, oe);
    chk(tag, "devselOe", devselOe, oe);
    if (oe) begin
      chk(tag, "devselN", devselN, dev);
      chk(tag, "trdyN", trdyN, trdy);
      chk(tag, "stopN", stopN, stop);
    end
    chk(tag, "adOe", adOe, adEn);
    chk(tag, "fifoPop", fifoPop, pop);
    if (adEn) chk(tag, "adOut", adOut, data);
  endtask

  // One read transaction, driven and checked clock by clock at negedges.
  task automatic doRead(input string tag, input logic [31:0] addr,
                        input logic [3:0] cmd, input logic [3:0] be,
                        input int waits, input bit burst);
    bit claim, isFifo, retry;
    logic [31:0] expData;
    int idx;
    idx    = int'(addr[5:2]);
    claim  = (addr[31:6] == BASE[31:6]) && (cmd == 4'b0110 || cmd == 4'b0010);
    isFifo = (idx == FIFO_SLOT);
    retry  = claim && isFifo && (fifoCnt == 0);
    expData = isFifo ? fifoMem[fifoRd[2:0]] : regMem[idx];
    // clock 1: address phase
    frameN = 1'b0; irdyN = 1'b1; adIn = addr; cbeN = cmd;
    @(negedge clk);
    // clock 2: claim, turnaround
    expectPins(tag, claim, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, '0);
    adIn = 32'h0; cbeN = be;
    for (int w = 0; w < waits; w++) begin
      irdyN = 1'b1; frameN = 1'b0;
      @(negedge clk);
      expectPins({tag, "/R4"}, claim, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, '0);
    end
    irdyN = 1'b0; frameN = burst ? 1'b0 : 1'b1;
    @(negedge clk);
    // data or retry clock
    expectPins(tag, claim, 1'b0, retry, !(retry || burst), claim && !retry, 1'b0, expData);
    @(negedge clk);
    // release clock with drivers on and all high
    expectPins({tag, "/R7"}, claim, 1'b1, 1'b1, 1'b1, 1'b0, claim && isFifo && !retry, '0);
    frameN = 1'b1; irdyN = 1'b1; cbeN = 4'hF;
    @(negedge clk);
    expectPins({tag, "/R7"}, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) regMem[i] = 32'hA500_0000 ^ (i * 32'h0101_1011);
    for (int i = 0; i < 8; i++)  fifoMem[i] = 32'hF1F0_0000 + i;
    repeat (3) @(negedge clk);
    expectPins("R1 reset", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, '0);
    rstN = 1'b1;
    @(negedge clk);

    doRead("R2 plain mem read",    BASE + 32'h0C, 4'b0110, 4'b0000, 0, 1'b0);
    doRead("R8 io read byte en",   BASE + 32'h00, 4'b0010, 4'b1110, 0, 1'b0);
    doRead("R3 burst attempt",     BASE + 32'h14, 4'b0110, 4'b0000, 0, 1'b1);
    doRead("R4 two waits",         BASE + 32'h20, 4'b0110, 4'b0101, 2, 1'b0);
    doRead("R3 burst after wait",  BASE + 32'h24, 4'b0110, 4'b0000, 1, 1'b1);
    doRead("R5 fifo empty retry",  BASE + 32'h3C, 4'b0110, 4'b0000, 0, 1'b0);
    fifoCnt = 3;
    doRead("R9 fifo pop",          BASE + 32'h3C, 4'b0110, 4'b0000, 0, 1'b0);
    doRead("R9 fifo burst pop",    BASE + 32'h3C, 4'b0110, 4'b0000, 1, 1'b1);
    chk("R9", "fifo entries left", 32'(fifoCnt), 32'd1);
    doRead("R10 write command",    BASE + 32'h08, 4'b0111, 4'b0000, 0, 1'b0);
    doRead("R10 outside window",   BASE + 32'h40, 4'b0110, 4'b0000, 0, 1'b0);
    doRead("R6 retry one left",    BASE + 32'h3C, 4'b0010, 4'b0011, 0, 1'b0);
    doRead("R5 retry again empty", BASE + 32'h3C, 4'b0110, 4'b0000, 1, 1'b0);
    chk("R9", "fifo entries after retry", 32'(fifoCnt), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule